// File: doc/BRIEF.md
# Clock Ratio Detector

This block runs on the master audio clock and times each frame of the left/right frame clock. It counts how many master clock cycles separate two rising edges of the frame clock. The count is sorted into one of three supported ratios, 256, 384 or 512, or marked invalid. A clock-valid flag is raised only after the measurement is stable. A one-cycle fault pulse feeds the loss-of-clock logic downstream. The frame clock is assumed to be synchronous to the master clock.

The block reports a fault in three cases. The first is a switch from one supported ratio to another while the clock is valid. The second is a measurement that matches no supported ratio. The third is a frame clock that has stalled. The stall is caught by a saturating counter, so it needs no second time base.

Top module: `ratio_detect`

## Requirements
- R1: The period is the number of `mclk` cycles between successive rising edges of `lrclk`. A period within ±2 of 256, 384 or 512 maps to the codes 0, 1 and 2 respectively.
- R2: A period outside all three windows is classified as invalid, code 3.
- R3: `clk_ok` rises only when two consecutive periods give the same valid code. While `clk_ok` is low, `ratio_code` reads 3.
- R4: While `clk_ok` is high, a period with a different valid code gives a one-cycle `loc_pulse` and clears `clk_ok`. Requalification then needs two matching periods at the new ratio.
- R5: While `clk_ok` is high, an invalid period gives a one-cycle `loc_pulse` and clears `clk_ok`.
- R6: If the cycle counter passes 1023 with no rising edge of `lrclk`, the block gives one `loc_pulse`, clears `clk_ok` and holds the counter saturated. The period that ends the stall reads as invalid and raises no further pulse.
- R7: `loc_pulse` lasts one cycle and fires only on a new fault. A second invalid period in a row raises no pulse.
- R8: After reset, `ratio_code` is 3, `clk_ok` is 0 and `loc_pulse` is 0. The first rising edge of `lrclk` after reset raises no fault.
- R9: While `clk_ok` stays high, `ratio_code` changes only at a rising edge of `lrclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lrclk | input | 1 | Frame clock, synchronous to `clk` |
| ratio_code | output | 2 | 0 = 256, 1 = 384, 2 = 512, 3 = invalid or not qualified |
| clk_ok | output | 1 | High when the clock ratio is qualified |
| loc_pulse | output | 1 | One-cycle pulse on each new clock fault |

## Verification
The hardest state to reach is a stall timeout that follows a qualified ratio. It needs a full 1024-cycle quiet interval on `lrclk`. After it comes a frame that must be read as invalid without a second pulse. The stimulus qualifies the 512 ratio first, holds `lrclk` for 1100 cycles, and then starts a fresh frame. It expects exactly one pulse, stamped at the cycle the counter saturates. The tolerance edges (258, 510 and an out-of-window 515) and a direct 256→384 switch are driven in the same sequence.

// File: rtl/ratio_detect.sv
module ratio_detect #(
  parameter int NOM_LO  = 256,
  parameter int NOM_MID = 384,
  parameter int NOM_HI  = 512,
  parameter int TOL     = 2,
  parameter int TMO     = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lrclk,
  output logic [1:0] ratio_code,
  output logic       clk_ok,
  output logic       loc_pulse
);
  localparam int CW = $clog2(TMO + 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(TMO);
  localparam logic [CW-1:0] CNT_LAST = CW'(TMO - 1);

  logic          lr_q;
  logic [CW-1:0] cnt;
  logic [1:0]    meas, prev;

  function automatic logic near(input logic [CW-1:0] c, input int nom);
    return (int'(c) >= nom - TOL) && (int'(c) <= nom + TOL);
  endfunction

  always_comb begin
    if      (near(cnt, NOM_LO))  meas = 2'd0;
    else if (near(cnt, NOM_MID)) meas = 2'd1;
    else if (near(cnt, NOM_HI))  meas = 2'd2;
    else                         meas = 2'd3;
  end

  wire rise    = lrclk & ~lr_q;
  wire stall   = ~rise && (cnt == CNT_LAST);
  wire change  = clk_ok && (meas != ratio_code);
  wire bad_new = (meas == 2'd3) && (prev != 2'd3);
  wire qualify = (meas != 2'd3) && (meas == prev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_q       <= 1'b0;
      cnt        <= CNT_SAT;
      prev       <= 2'd3;
      ratio_code <= 2'd3;
      clk_ok     <= 1'b0;
      loc_pulse  <= 1'b0;
    end else begin
      lr_q      <= lrclk;
      loc_pulse <= 1'b0;
      if (rise) begin
        cnt       <= CW'(1);
        prev      <= meas;
        loc_pulse <= change | bad_new;
        if (qualify) begin
          clk_ok     <= 1'b1;
          ratio_code <= meas;
        end else begin
          clk_ok     <= 1'b0;
          ratio_code <= 2'd3;
        end
      end else if (cnt != CNT_SAT) begin
        cnt <= cnt + CW'(1);
        if (stall) begin
          loc_pulse  <= 1'b1;
          clk_ok     <= 1'b0;
          ratio_code <= 2'd3;
          prev       <= 2'd3;
        end
      end
    end
  end
endmodule

module ratio_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lrclk,
  input logic [1:0] ratio_code,
  input logic       clk_ok,
  input logic       loc_pulse
);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    loc_pulse |=> !loc_pulse);

  a_r4_fault_clears_ok: assert property (@(posedge clk) disable iff (!rst_n)
    loc_pulse |-> !clk_ok);

  a_r3_code_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_ok |-> ratio_code == 2'd3);

  a_r1_code_when_ok: assert property (@(posedge clk) disable iff (!rst_n)
    clk_ok |-> ratio_code != 2'd3);

  a_r3_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_ok) |-> $past(lrclk) && !$past(lrclk, 2));

  a_r9_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_ok && $past(clk_ok) && !($past(lrclk) && !$past(lrclk, 2)))
      |-> $stable(ratio_code));
endmodule

bind ratio_detect ratio_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lrclk(lrclk),
  .ratio_code(ratio_code), .clk_ok(clk_ok), .loc_pulse(loc_pulse)
);

// File: tb/ratio_detect_bench.sv
module ratio_detect_bench;
  logic clk = 1'b0, rst_n = 1'b0, lrclk = 1'b0;
  logic [1:0] ratio_code;
  logic clk_ok, loc_pulse;
  int cyc = 0, checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {
    int         at;
    logic [1:0] r;
    logic       v;
    logic       f;
    string      tag;
  } exp_t;
  exp_t q[$];

  ratio_detect u_ratio_detect (
    .clk(clk), .rst_n(rst_n), .lrclk(lrclk),
    .ratio_code(ratio_code), .clk_ok(clk_ok), .loc_pulse(loc_pulse)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && q.size() > 0 && q[0].at == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (ratio_code !== e.r || clk_ok !== e.v || loc_pulse !== e.f) begin
        fails++;
        $display("FAIL %s: got r=%0d v=%0b f=%0b exp r=%0d v=%0b f=%0b",
                 e.tag, ratio_code, clk_ok, loc_pulse, e.r, e.v, e.f);
      end
    end else if (rst_n) begin
      checks++;
      if (loc_pulse !== 1'b0) begin
        fails++;
        $display("FAIL R7: unexpected pulse at cycle %0d got f=1 exp f=0", cyc);
      end
    end
  end

  task automatic edge_exp(input logic [1:0] r, input logic v, input logic f, input string tag);
    exp_t e;
    @(negedge clk);
    lrclk = 1'b1;
    e.at = cyc + 1; e.r = r; e.v = v; e.f = f; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic hold(input int n);
    repeat (n / 2 - 1) @(negedge clk);
    lrclk = 1'b0;
    repeat (n - n / 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (ratio_code !== 2'd3 || clk_ok !== 1'b0 || loc_pulse !== 1'b0) begin
      fails++;
      $display("FAIL R8: reset got r=%0d v=%0b f=%0b exp r=3 v=0 f=0", ratio_code, clk_ok, loc_pulse);
    end
    edge_exp(2'd3, 1'b0, 1'b0, "R8 first edge");    hold(256);
    edge_exp(2'd3, 1'b0, 1'b0, "R3 one period");    hold(256);
    edge_exp(2'd0, 1'b1, 1'b0, "R3 qualify 256");   hold(258);
    edge_exp(2'd0, 1'b1, 1'b0, "R1 tol +2");        hold(384);
    edge_exp(2'd3, 1'b0, 1'b1, "R4 256 to 384");    hold(384);
    edge_exp(2'd1, 1'b1, 1'b0, "R4 requalify 384"); hold(300);
    edge_exp(2'd3, 1'b0, 1'b1, "R5 invalid 300");   hold(300);
    edge_exp(2'd3, 1'b0, 1'b0, "R7 repeat invalid"); hold(512);
    edge_exp(2'd3, 1'b0, 1'b0, "R2 after invalid"); hold(512);
    edge_exp(2'd2, 1'b1, 1'b0, "R1 qualify 512");   hold(510);
    edge_exp(2'd2, 1'b1, 1'b0, "R1 tol -2");        hold(515);
    edge_exp(2'd3, 1'b0, 1'b1, "R2 515 out");       hold(512);
    edge_exp(2'd3, 1'b0, 1'b0, "R3 one of two");    hold(512);
    edge_exp(2'd2, 1'b1, 1'b0, "R9 held 512");
    begin
      exp_t e;
      e.at = cyc + 1024; e.r = 2'd3; e.v = 1'b0; e.f = 1'b1; e.tag = "R6 stall";
      q.push_back(e);
    end
    hold(1100);
    edge_exp(2'd3, 1'b0, 1'b0, "R6 after stall");   hold(384);
    edge_exp(2'd3, 1'b0, 1'b0, "R3 one of two");    hold(384);
    edge_exp(2'd1, 1'b1, 1'b0, "R3 recover 384");   hold(20);
    repeat (5) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R1: %0d expectations unchecked exp 0", q.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung exp done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule